// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

The engine works through a circular list of transmit descriptors kept in a single-port synchronous memory. Each descriptor takes two consecutive 32-bit words. The first word is the control/status word and the second is the byte address of a data buffer. The engine looks for a frame the host has made ready and fetches that frame's buffers one byte at a time. A frame that spans several buffers is joined into one byte stream with a valid/ready handshake, and the final byte is marked last. When the engine is done with a descriptor, it writes the control/status word back with ownership returned to the host and any error flags it raised.

The host pulses `start` to switch the transmitter on. It also supplies the ring's base word address, the number of descriptors, a mode bit that selects how an underflow is recovered, and an enable for recording parity faults. The byte-fetch port reports whether the byte is available in the same cycle, so a slow memory shows up as gaps. A gap that lasts too long is treated as the data path running dry.

Control/status word layout:

| Bits | Field |
|------|-------|
| 31 | host-owned flag; 1 = the engine may use the descriptor |
| 25 | frame-start marker |
| 24 | frame-end marker |
| 22 | chain-break error |
| 21 | underflow error |
| 20 | parity error |
| 15:12 | written as ones by the host |
| 11:0 | twos complement of the buffer length |

Top module: `tdr_engine`

## Requirements
- R1: While reset is high and after it is released, before any `start`, `tx_valid` and `tx_on` are 0 and no descriptor write takes place.
- R2: A frame begins only at a descriptor with bit 31 and bit 25 both set. A descriptor with bit 31 set and bit 25 clear is passed over without any write-back, and polling moves to the following index. A descriptor with bit 31 clear is polled again until it changes.
- R3: Each buffer supplies (4096 − bits 11:0) mod 4096 bytes. The bytes are fetched from ascending addresses starting at the buffer address in word 1. A count of 0 supplies no bytes.
- R4: Buffers from the start descriptor through the descriptor with bit 24 set make up one continuous stream. `tx_last` is high only on the final byte of the bit-24 buffer, or on a truncating byte.
- R5: After index `ring_len`−1 the descriptor index wraps to 0.
- R6: Each descriptor the engine uses gets exactly one write-back. That write-back clears bit 31, keeps bits 25, 24 and 15:0 as written, and sets error bits 22:20 only as raised.
- R7: An underflow is raised when `fetch_avail` stays low for `STALL_LIMIT` consecutive cycles while a byte is requested. The engine then emits a truncating byte 0x00 with `tx_last` set and sets bit 21 in the current descriptor.
- R8: When a buffer without bit 24 is used up and the next descriptor has bit 31 clear, the engine sets bits 22 and 21 in the current descriptor and emits a truncating byte 0x00 with `tx_last`.
- R9: With `uflo_recover` = 0, an underflow or chain-break drops `tx_on`. No descriptor or byte access follows until the next `start`.
- R10: With `uflo_recover` = 1, after an underflow the engine keeps `tx_on` high. It passes over owned non-start descriptors and begins the next frame at a start descriptor.
- R11: Bit 20 is set in a descriptor's write-back only when a byte of its buffer came with `fetch_perr` high while `par_en` was 1. The byte itself is still streamed.
- R12: While `tx_valid` is high and `tx_ready` low, `tx_valid`, `tx_data` and `tx_last` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that turns the transmitter on |
| ring_base | input | ADDR_W | Word address of descriptor 0 |
| ring_len | input | IDX_W | Number of descriptors in the ring |
| uflo_recover | input | 1 | 1 = continue at the next frame after an underflow |
| par_en | input | 1 | Enables recording of parity faults |
| dm_rd | output | 1 | Descriptor memory read; data returns the next cycle |
| dm_we | output | 1 | Descriptor memory write |
| dm_addr | output | ADDR_W | Descriptor memory word address |
| dm_wdata | output | 32 | Descriptor write-back word |
| dm_rdata | input | 32 | Descriptor memory read data |
| fetch_req | output | 1 | Buffer byte request |
| fetch_addr | output | ADDR_W | Buffer byte address |
| fetch_data | input | 8 | Buffer byte |
| fetch_avail | input | 1 | Byte is available this cycle |
| fetch_perr | input | 1 | Parity fault on this byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Last byte of the frame |
| tx_ready | input | 1 | Stream sink accepts the byte |
| tx_on | output | 1 | Transmitter running |

## Verification
Most internal mistakes surface at the ports within a single frame. A wrong index step or a missed wrap makes a wrong buffer's bytes appear. A bad remaining count moves `tx_last` or changes the frame length by some bytes. A lost error flag turns up in the write-back word as soon as that descriptor is released. A stall counter that is wrong either truncates frames that a short gap should not affect, or never truncates. In both cases the effect shows within a few cycles of the `fetch_avail` gap, as an unexpected 0x00 last byte or a missing one, and in the `tx_on` level that follows.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

    localparam int OWN_B  = 31;
    localparam int STP_B  = 25;
    localparam int ENP_B  = 24;
    localparam int BUFF_B = 22;
    localparam int UFLO_B = 21;
    localparam int BPE_B  = 20;
    localparam int LEN_W  = 13;

    typedef enum logic [3:0] {
        S_IDLE, S_POLL_RD, S_POLL_CHK, S_PTR_RD, S_PTR_WT, S_STREAM,
        S_END_BUF, S_NEXT_RD, S_NEXT_CHK, S_TRUNC, S_WB
    } st_e;

    typedef enum logic [1:0] { AF_DONE, AF_CHAIN, AF_UNDER } after_e;

    typedef struct packed {
        logic buff;
        logic uflo;
        logic bpe;
    } err_t;

    // Negative count to byte length; a zero field means an empty buffer.
    function automatic logic [LEN_W-1:0] buf_len(input logic [11:0] cnt);
        return (cnt == 12'd0) ? '0 : (13'd4096 - {1'b0, cnt});
    endfunction

    function automatic logic [31:0] wb_word(input logic [31:0] w, input err_t e);
        logic [31:0] r;
        r = w;
        r[OWN_B]  = 1'b0;
        r[BUFF_B] = w[BUFF_B] | e.buff;
        r[UFLO_B] = w[UFLO_B] | e.uflo;
        r[BPE_B]  = w[BPE_B]  | e.bpe;
        return r;
    endfunction

endpackage

// File: rtl/tdr_out_reg.sv
module tdr_out_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] ld_data,
    input  logic         ld_last,
    input  logic         tx_ready,
    output logic         tx_valid,
    output logic [W-1:0] tx_data,
    output logic         tx_last,
    output logic         slot_free
);

    assign slot_free = !tx_valid || tx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
            tx_last  <= 1'b0;
        end else if (load) begin
            tx_valid <= 1'b1;
            tx_data  <= ld_data;
            tx_last  <= ld_last;
        end else if (tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

    a_r12_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

endmodule

// File: rtl/tdr_stall_watch.sv
module tdr_stall_watch #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic avail,
    output logic dry
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign dry = req && !avail && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (req && !avail && !dry)
            cnt <= cnt + 1'b1;
        else
            cnt <= '0;
    end

    a_r7_count_below_limit: assert property (@(posedge clk) disable iff (rst)
        (req && !avail && !dry) |=> (cnt != '0));

endmodule

// File: rtl/tdr_engine.sv
module tdr_engine
    import tdr_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int IDX_W       = 8,
    parameter int STALL_LIMIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [IDX_W-1:0]  ring_len,
    input  logic              uflo_recover,
    input  logic              par_en,
    output logic              dm_rd,
    output logic              dm_we,
    output logic [ADDR_W-1:0] dm_addr,
    output logic [31:0]       dm_wdata,
    input  logic [31:0]       dm_rdata,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic [7:0]        fetch_data,
    input  logic              fetch_avail,
    input  logic              fetch_perr,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              tx_on
);

    st_e               state;
    after_e            after;
    err_t              err;
    logic [IDX_W-1:0]  idx, nidx;
    logic [IDX_W:0]    inc;
    logic [31:0]       cur_w0, nxt_w0;
    logic [ADDR_W-1:0] ptr, cur_wa, nxt_wa;
    logic [LEN_W-1:0]  rem, new_len;
    logic              slot_free, dry, ld, ld_last, accept;
    logic [7:0]        ld_data;

    // Ring index arithmetic
    assign inc     = {1'b0, idx} + 1'b1;
    assign nidx    = (inc >= {1'b0, ring_len}) ? '0 : inc[IDX_W-1:0];
    assign cur_wa  = ring_base + ADDR_W'({idx, 1'b0});
    assign nxt_wa  = ring_base + ADDR_W'({nidx, 1'b0});
    assign new_len = buf_len(cur_w0[11:0]);
    assign fetch_addr = ptr;
    assign accept  = fetch_req && fetch_avail;

    tdr_out_reg #(.W(8)) u_out (
        .clk(clk), .rst(rst), .load(ld), .ld_data(ld_data), .ld_last(ld_last),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .slot_free(slot_free)
    );

    tdr_stall_watch #(.LIMIT(STALL_LIMIT)) u_watch (
        .clk(clk), .rst(rst), .req(fetch_req), .avail(fetch_avail), .dry(dry)
    );

    always_comb begin
        dm_rd     = 1'b0;
        dm_we     = 1'b0;
        dm_addr   = cur_wa;
        dm_wdata  = wb_word(cur_w0, err);
        fetch_req = 1'b0;
        ld        = 1'b0;
        ld_data   = fetch_data;
        ld_last   = 1'b0;
        case (state)
            S_POLL_RD: dm_rd = 1'b1;
            S_PTR_RD: begin
                dm_rd   = 1'b1;
                dm_addr = cur_wa + 1'b1;
            end
            S_NEXT_RD: begin
                dm_rd   = 1'b1;
                dm_addr = nxt_wa;
            end
            S_WB: dm_we = 1'b1;
            S_STREAM: begin
                if (slot_free) begin
                    fetch_req = 1'b1;
                    if (fetch_avail) begin
                        ld      = 1'b1;
                        ld_last = cur_w0[ENP_B] && (rem == LEN_W'(1));
                    end else if (dry) begin
                        ld      = 1'b1;
                        ld_data = 8'h00;
                        ld_last = 1'b1;
                    end
                end
            end
            S_TRUNC: begin
                if (slot_free) begin
                    ld      = 1'b1;
                    ld_data = 8'h00;
                    ld_last = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            after  <= AF_DONE;
            err    <= '0;
            idx    <= '0;
            cur_w0 <= '0;
            nxt_w0 <= '0;
            ptr    <= '0;
            rem    <= '0;
            tx_on  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        tx_on <= 1'b1;
                        state <= S_POLL_RD;
                    end
                end
                S_POLL_RD: state <= S_POLL_CHK;
                S_POLL_CHK: begin
                    if (dm_rdata[OWN_B] && dm_rdata[STP_B]) begin
                        cur_w0 <= dm_rdata;
                        err    <= '0;
                        state  <= S_PTR_RD;
                    end else begin
                        if (dm_rdata[OWN_B])
                            idx <= nidx;
                        state <= S_POLL_RD;
                    end
                end
                S_PTR_RD: state <= S_PTR_WT;
                S_PTR_WT: begin
                    ptr   <= dm_rdata[ADDR_W-1:0];
                    rem   <= new_len;
                    state <= (new_len == '0) ? S_END_BUF : S_STREAM;
                end
                S_STREAM: begin
                    if (accept) begin
                        ptr     <= ptr + 1'b1;
                        rem     <= rem - 1'b1;
                        err.bpe <= err.bpe | (fetch_perr & par_en);
                        if (rem == LEN_W'(1))
                            state <= S_END_BUF;
                    end else if (ld) begin
                        err.uflo <= 1'b1;
                        after    <= AF_UNDER;
                        state    <= S_WB;
                    end
                end
                S_END_BUF: begin
                    if (cur_w0[ENP_B]) begin
                        after <= AF_DONE;
                        state <= S_WB;
                    end else begin
                        state <= S_NEXT_RD;
                    end
                end
                S_NEXT_RD: state <= S_NEXT_CHK;
                S_NEXT_CHK: begin
                    if (dm_rdata[OWN_B]) begin
                        nxt_w0 <= dm_rdata;
                        after  <= AF_CHAIN;
                        state  <= S_WB;
                    end else begin
                        err.buff <= 1'b1;
                        err.uflo <= 1'b1;
                        after    <= AF_UNDER;
                        state    <= S_TRUNC;
                    end
                end
                S_TRUNC: if (slot_free) state <= S_WB;
                S_WB: begin
                    idx <= nidx;
                    err <= '0;
                    case (after)
                        AF_CHAIN: begin
                            cur_w0 <= nxt_w0;
                            state  <= S_PTR_RD;
                        end
                        AF_UNDER: begin
                            if (uflo_recover) begin
                                state <= S_POLL_RD;
                            end else begin
                                tx_on <= 1'b0;
                                state <= S_IDLE;
                            end
                        end
                        default: state <= S_POLL_RD;
                    endcase
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    a_r6_own_released: assert property (@(posedge clk) disable iff (rst)
        dm_we |-> !dm_wdata[OWN_B]);

    a_r8_buff_with_uflo: assert property (@(posedge clk) disable iff (rst)
        (dm_we && dm_wdata[BUFF_B]) |-> dm_wdata[UFLO_B]);

    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !tx_on |-> !(dm_rd || dm_we || fetch_req));

    a_r5_wrap_step: assert property (@(posedge clk) disable iff (rst)
        (state == S_WB) |=> (idx == '0 || idx == $past(idx) + 1'b1));

    a_r7_trunc_marked: assert property (@(posedge clk) disable iff (rst)
        (state == S_STREAM && dry && slot_free) |=> (tx_valid && tx_last && tx_data == 8'h00));

    a_r2_frame_start: assert property (@(posedge clk) disable iff (rst)
        (state == S_PTR_RD && $past(state) == S_POLL_CHK) |-> (cur_w0[OWN_B] && cur_w0[STP_B]));

endmodule

// File: tb/sim_tdr_engine.sv
module sim_tdr_engine;

    localparam int AW = 16;
    localparam int IW = 8;
    localparam int DB = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst = 1'b1, start = 1'b0, uflo_recover = 1'b0, par_en = 1'b0;
    logic [AW-1:0]  ring_base = AW'(DB);
    logic [IW-1:0]  ring_len = 8'd3;
    logic           dm_rd, dm_we, fetch_req, fetch_avail, fetch_perr;
    logic [AW-1:0]  dm_addr, fetch_addr;
    logic [31:0]    dm_wdata, dm_rdata;
    logic [7:0]     fetch_data, tx_data;
    logic           tx_valid, tx_last, tx_on;
    logic           tx_ready = 1'b1;

    tdr_engine #(.ADDR_W(AW), .IDX_W(IW), .STALL_LIMIT(4)) u0 (
        .clk(clk), .rst(rst), .start(start), .ring_base(ring_base), .ring_len(ring_len),
        .uflo_recover(uflo_recover), .par_en(par_en), .dm_rd(dm_rd), .dm_we(dm_we),
        .dm_addr(dm_addr), .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
        .fetch_avail(fetch_avail), .fetch_perr(fetch_perr), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready), .tx_on(tx_on)
    );

    logic [31:0] mem [0:63];
    logic        h_we = 1'b0;
    logic [5:0]  h_addr = '0;
    logic [31:0] h_data = '0;

    always @(posedge clk) begin
        if (dm_rd) dm_rdata <= mem[dm_addr[5:0]];
        if (dm_we) mem[dm_addr[5:0]] <= dm_wdata;
        if (h_we)  mem[h_addr] <= h_data;
    end

    function automatic logic [7:0] bval(input logic [15:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    endfunction

    logic          av_r = 1'b1;
    logic [15:0]   hole = 16'hFFFF, perr_at = 16'hFFFF;
    logic          rnd_on = 1'b0;
    int            lowrun = 0;

    assign fetch_data  = bval(fetch_addr);
    assign fetch_avail = av_r && (fetch_addr != hole);
    assign fetch_perr  = (fetch_addr == perr_at);

    logic [7:0] got_b [$];
    logic       got_l [$];
    logic [7:0] exp_b [$];
    logic       exp_l [$];

    always @(negedge clk) begin
        if (rnd_on) begin
            tx_ready = ($urandom % 4) != 0;
            if (lowrun >= 2) av_r = 1'b1;
            else             av_r = ($urandom % 3) != 0;
            lowrun = av_r ? 0 : lowrun + 1;
        end else begin
            tx_ready = 1'b1;
            av_r     = 1'b1;
            lowrun   = 0;
        end
        if (tx_valid && tx_ready) begin
            got_b.push_back(tx_data);
            got_l.push_back(tx_last);
        end
    end

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] M_UFLO = 32'h0020_0000;
    localparam logic [31:0] M_BUFF = 32'h0040_0000;
    localparam logic [31:0] M_BPE  = 32'h0010_0000;
    localparam logic [31:0] M_REL  = 32'h7FFF_FFFF;

    function automatic logic [31:0] mkd(input logic own, input logic stp, input logic enp, input int len);
        logic [11:0] c;
        c = 12'(4096 - len);
        return {own, 5'b0, stp, enp, 8'h00, 4'hF, c};
    endfunction

    task automatic hwr(input int a, input logic [31:0] d);
        @(negedge clk);
        h_we = 1'b1; h_addr = 6'(a); h_data = d;
    endtask

    task automatic hend();
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic setd(input int i, input logic [31:0] w0, input logic [15:0] a);
        hwr(DB + 2*i + 1, {16'h0, a});
        hwr(DB + 2*i, w0);
    endtask

    task automatic expbuf(input logic [15:0] a, input int len, input logic lastf);
        for (int j = 0; j < len; j++) begin
            exp_b.push_back(bval(a + 16'(j)));
            exp_l.push_back(lastf && (j == len - 1));
        end
    endtask

    task automatic exp_trunc();
        exp_b.push_back(8'h00);
        exp_l.push_back(1'b1);
    endtask

    task automatic begin_scn(input int n, input logic rec, input logic pe);
        @(negedge clk);
        rst = 1'b1;
        ring_len = IW'(n); uflo_recover = rec; par_en = pe;
        hole = 16'hFFFF; perr_at = 16'hFFFF;
        got_b.delete(); got_l.delete(); exp_b.delete(); exp_l.delete();
        for (int k = 0; k < 64; k++) hwr(k, 32'h0);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic go();
        hend();
        @(negedge clk); rst = 1'b0;
        pulse_start();
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        while (got_b.size() < exp_b.size() && t < 4000) begin
            @(negedge clk);
            t++;
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic chk_stream(input string r);
        int bad;
        bad = -1;
        checks++;
        if (got_b.size() != exp_b.size()) begin
            errors++;
            $display("FAIL %s stream length actual=%0d expected=%0d", r, got_b.size(), exp_b.size());
        end else begin
            for (int j = 0; j < exp_b.size(); j++)
                if (bad < 0 && (got_b[j] !== exp_b[j] || got_l[j] !== exp_l[j])) bad = j;
            if (bad >= 0) begin
                errors++;
                $display("FAIL %s byte %0d actual=%h/%0b expected=%h/%0b", r, bad,
                         got_b[bad], got_l[bad], exp_b[bad], exp_l[bad]);
            end
        end
    endtask

    task automatic chk_word(input string r, input int a, input logic [31:0] e);
        checks++;
        if (mem[a] !== e) begin
            errors++;
            $display("FAIL %s word %0d actual=%h expected=%h", r, a, mem[a], e);
        end
    endtask

    task automatic chk_bit(input string r, input logic act, input logic e);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", r, act, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] w [0:7];
        logic [31:0] wa, wb, wc;
        int n, k, nb, ln;
        void'($urandom(32'h00C0FFEE));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk_bit("R1 tx_valid in reset", tx_valid, 1'b0);
        chk_bit("R1 tx_on in reset", tx_on, 1'b0);
        @(negedge clk); rst = 1'b0;
        repeat (3) @(negedge clk);
        chk_bit("R1 tx_on before start", tx_on, 1'b0);
        chk_bit("R1 no write before start", dm_we, 1'b0);

        // R3 R4 R6 R12: random chained frames with random ready and short gaps
        for (int it = 0; it < 4; it++) begin
            n = 3 + int'($urandom % 6);
            begin_scn(n, 1'b0, 1'b0);
            k = 0;
            while (k < n - 1) begin
                nb = 1 + int'($urandom % 2);
                if (nb > n - 1 - k) nb = n - 1 - k;
                for (int b = 0; b < nb; b++) begin
                    ln = 1 + int'($urandom % 8);
                    w[k] = mkd(1'b1, b == 0, b == nb - 1, ln);
                    setd(k, w[k], 16'h0200 + 16'(k * 16));
                    expbuf(16'h0200 + 16'(k * 16), ln, b == nb - 1);
                    k++;
                end
            end
            rnd_on = 1'b1;
            go();
            wait_done();
            rnd_on = 1'b0;
            chk_stream("R4 R12 random chained stream");
            for (int i = 0; i < n - 1; i++) chk_word("R6 released word", DB + 2*i, w[i] & M_REL);
            chk_word("R2 unowned entry untouched", DB + 2*(n - 1), 32'h0);
            chk_bit("R3 tx_on stays up", tx_on, 1'b1);
        end

        // R2: owned descriptor without start marker is skipped
        begin_scn(3, 1'b0, 1'b0);
        wa = mkd(1'b1, 1'b0, 1'b1, 4); setd(0, wa, 16'h0300);
        wb = mkd(1'b1, 1'b1, 1'b1, 5); setd(1, wb, 16'h0340);
        expbuf(16'h0340, 5, 1'b1);
        go(); wait_done();
        chk_stream("R2 skip non-start");
        chk_word("R2 skipped word unchanged", DB, wa);
        chk_word("R6 sent word released", DB + 2, wb & M_REL);

        // R3: zero-length middle buffer
        begin_scn(5, 1'b0, 1'b0);
        setd(0, mkd(1'b1, 1'b1, 1'b0, 3), 16'h0380);
        setd(1, mkd(1'b1, 1'b0, 1'b0, 0), 16'h03A0);
        setd(2, mkd(1'b1, 1'b0, 1'b1, 2), 16'h03C0);
        expbuf(16'h0380, 3, 1'b0); expbuf(16'h03C0, 2, 1'b1);
        go(); wait_done();
        chk_stream("R3 empty buffer in chain");
        chk_word("R6 empty buffer released", DB + 2, mkd(1'b0, 1'b0, 1'b0, 0));

        // R5: index wrap
        begin_scn(3, 1'b0, 1'b0);
        setd(0, mkd(1'b1, 1'b1, 1'b1, 3), 16'h0800);
        setd(1, mkd(1'b1, 1'b1, 1'b1, 2), 16'h0840);
        expbuf(16'h0800, 3, 1'b1); expbuf(16'h0840, 2, 1'b1);
        go(); wait_done();
        wc = mkd(1'b1, 1'b1, 1'b1, 2);
        setd(0, wc, 16'h08C0);
        setd(2, mkd(1'b1, 1'b1, 1'b1, 4), 16'h0880);
        hend();
        expbuf(16'h0880, 4, 1'b1); expbuf(16'h08C0, 2, 1'b1);
        wait_done();
        chk_stream("R5 wrap to index 0");
        chk_word("R5 wrapped entry released", DB, wc & M_REL);

        // R7 R9: underflow, recovery off
        begin_scn(4, 1'b0, 1'b0);
        wa = mkd(1'b1, 1'b1, 1'b1, 10); setd(0, wa, 16'h0400);
        wb = mkd(1'b1, 1'b1, 1'b1, 3);  setd(1, wb, 16'h0480);
        hole = 16'h0403;
        expbuf(16'h0400, 3, 1'b0); exp_trunc();
        go(); wait_done();
        chk_stream("R7 truncated frame");
        chk_word("R7 underflow flag", DB, (wa & M_REL) | M_UFLO);
        chk_bit("R9 tx_on dropped", tx_on, 1'b0);
        chk_word("R9 next frame untouched", DB + 2, wb);
        pulse_start();
        expbuf(16'h0480, 3, 1'b1);
        wait_done();
        chk_stream("R9 restart resumes");
        chk_word("R9 resumed word released", DB + 2, wb & M_REL);

        // R10: underflow, recovery on
        begin_scn(5, 1'b1, 1'b0);
        wa = mkd(1'b1, 1'b1, 1'b0, 6); setd(0, wa, 16'h0500);
        wb = mkd(1'b1, 1'b0, 1'b1, 4); setd(1, wb, 16'h0540);
        wc = mkd(1'b1, 1'b1, 1'b1, 3); setd(2, wc, 16'h0580);
        hole = 16'h0502;
        expbuf(16'h0500, 2, 1'b0); exp_trunc(); expbuf(16'h0580, 3, 1'b1);
        go(); wait_done();
        chk_stream("R10 recover at next start");
        chk_word("R10 tail buffer skipped", DB + 2, wb);
        chk_word("R7 truncated entry flag", DB, (wa & M_REL) | M_UFLO);
        chk_bit("R10 tx_on kept", tx_on, 1'b1);

        // R8: chain break
        begin_scn(3, 1'b0, 1'b0);
        wa = mkd(1'b1, 1'b1, 1'b0, 4); setd(0, wa, 16'h0600);
        expbuf(16'h0600, 4, 1'b0); exp_trunc();
        go(); wait_done();
        chk_stream("R8 chain break truncation");
        chk_word("R8 buffer and underflow flags", DB, (wa & M_REL) | M_BUFF | M_UFLO);
        chk_bit("R9 tx_on dropped after chain break", tx_on, 1'b0);

        // R11: parity recording enabled and disabled
        for (int pe = 1; pe >= 0; pe--) begin
            begin_scn(3, 1'b0, pe == 1);
            wa = mkd(1'b1, 1'b1, 1'b1, 5); setd(0, wa, 16'h0700);
            perr_at = 16'h0702;
            expbuf(16'h0700, 5, 1'b1);
            go(); wait_done();
            chk_stream("R11 bytes unaffected by parity");
            chk_word("R11 parity flag", DB, (wa & M_REL) | ((pe == 1) ? M_BPE : 32'h0));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule